// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Flag Byte

This block is the combinational datapath core of a small eight-bit processor. It takes the accumulator, a second operand byte, the current flag byte and a four-bit operation code. In the same cycle it returns the new result byte and the new flag byte. The surrounding control logic writes the result back to the accumulator and the flags back to the flag register. Because there are no registers inside the block, a new operation can be issued every cycle.

The flag byte has a fixed bit layout that the branch and condition logic decodes. The block also reproduces the two spare flag bits, which take copies of bits 5 and 3. This includes their special sources for compare and complement-carry. Decimal adjust is implemented with its full rule set for both the addition and the subtraction direction.

Top module: `alu8_core`

## Requirements
- R1: The flag byte is laid out as bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half-carry, bit 3 copy of result bit 3, bit 2 parity/overflow, bit 1 subtract marker, bit 0 carry. Sign and zero are taken from the result byte for every operation that writes all of its flags.
- R2: Code 0 (add) and code 1 (add with incoming carry bit 0) return acc + opnd (+ carry). Half-carry is the carry out of bit 3 and carry is the carry out of bit 7. Bit 2 is set on signed overflow and the subtract marker is cleared.
- R3: Code 2 (subtract) and code 3 (subtract with incoming carry as borrow) return acc - opnd (- carry). Half-carry and carry mark the borrows into bit 4 and out of bit 7. Bit 2 is set on signed overflow and the subtract marker is set.
- R4: Code 4 (compare) sets the flags exactly as subtraction would, except that bits 5 and 3 are copied from the operand. The result output equals the accumulator.
- R5: Codes 5, 6 and 7 return AND, OR and XOR of the two bytes. Half-carry is 1 for AND and 0 for OR and XOR. Carry and the subtract marker are 0, and bit 2 is 1 when the result has an even number of ones.
- R6: Code 8 (increment) and code 9 (decrement) ignore the operand and return acc + 1 and acc - 1. Half-carry and overflow are computed as in R2 and R3, the subtract marker is 0 for increment and 1 for decrement, and carry keeps its incoming value.
- R7: Code 10 returns the bitwise inverse of the accumulator. It sets half-carry and the subtract marker, copies result bits 5 and 3, and keeps sign, zero, bit 2 and carry.
- R8: Code 11 returns the accumulator unchanged. It moves the old carry into half-carry, inverts carry and clears the subtract marker. Bits 5 and 3 become their old value ORed with accumulator bits 5 and 3, and the other flags are kept.
- R9: Code 12 (decimal adjust) builds a correction from two parts. It includes 0x06 when half-carry is set or the low nibble exceeds 9, and 0x60 when carry is set or the accumulator exceeds 0x99. The correction is subtracted when the subtract marker is 1 and added otherwise. New carry is old carry OR (acc > 0x99), new half-carry is acc bit 4 XOR result bit 4, bit 2 is even parity of the result, and the subtract marker is kept.
- R10: Codes 13 to 15 return the accumulator and the incoming flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand byte |
| flags_in | input | 8 | Current flag byte |
| op | input | 4 | Operation code |
| result | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |

## Verification
The assertions inside the top module check, whenever the inputs change, the rules that hold independently of the data values. These are: compare leaves the result equal to the accumulator, increment and decrement keep carry, logic operations clear carry and the subtract marker, and subtracting operations set that marker. They also check that complement-carry swaps carry into half-carry and that unused codes pass everything through. The arithmetic values themselves can only be shown by the bench. That covers sums, borrows, overflow, parity, the decimal-adjust corrections and the operand-sourced bits in compare. The bench sweeps every accumulator and operand pair with both carry values under every code, with the remaining flag bits randomised. It also drives directed boundary values.

// File: rtl/alu8_pkg.sv
// Shared definitions for the eight-bit ALU: operation codes, flag bit
// positions and small helper functions. Assumes an eight-bit data path.
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    // Operation codes; 13..15 are unused and pass data through.
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_CPL = 4'd10,
        OP_CCF = 4'd11,
        OP_DAA = 4'd12
    } alu_op_e;

    // Flag byte bit positions (decoded by neighbouring logic).
    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_PV = 2;
    localparam int FB_B3 = 3;
    localparam int FB_H  = 4;
    localparam int FB_B5 = 5;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    // Logic unit selections.
    localparam logic [1:0] LG_AND = 2'd0;
    localparam logic [1:0] LG_OR  = 2'd1;
    localparam logic [1:0] LG_XOR = 2'd2;

    // Even parity: 1 when the byte holds an even number of ones.
    function automatic logic even_par(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    // Assemble a flag byte from its individual fields.
    function automatic logic [DATA_W-1:0] pack_flags(
        input logic s, input logic z, input logic b5, input logic h,
        input logic b3, input logic pv, input logic n, input logic c);
        logic [DATA_W-1:0] f;
        f        = '0;
        f[FB_S]  = s;
        f[FB_Z]  = z;
        f[FB_B5] = b5;
        f[FB_H]  = h;
        f[FB_B3] = b3;
        f[FB_PV] = pv;
        f[FB_N]  = n;
        f[FB_C]  = c;
        return f;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
// Combined adder/subtractor. With sub=1 it computes a - b - cin, and its
// half/carry outputs then report borrows. Assumes W is even, so the half
// carry sits at the nibble boundary W/2.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         half,
    output logic         carry,
    output logic         ovf
);
    localparam int HW = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [HW:0]  low_sum;
    logic [W:0]   full_sum;

    // Invert operand and carry for subtraction (two's complement).
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = cin ^ sub;
    end

    // Low-half and full-width sums, borrow taken as inverted carry.
    always_comb begin
        low_sum  = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum      = full_sum[W-1:0];
        half     = low_sum[HW] ^ sub;
        carry    = full_sum[W] ^ sub;
        ovf      = (a[W-1] == b_eff[W-1]) && (full_sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu8_logic.sv
// Bitwise logic unit: AND, OR or XOR of two words, chosen by sel.
// Assumes sel values from alu8_pkg; any other value yields zero.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] res
);
    // Pick the bitwise function.
    always_comb begin
        unique case (sel)
            LG_AND:  res = a & b;
            LG_OR:   res = a | b;
            LG_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu8_decadj.sv
// Decimal adjust of a byte after a BCD add or subtract. The prior
// operation direction is given by n_in, and the half and carry flags
// select the nibble corrections. Assumes an eight-bit BCD value.
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic              c_in,
    input  logic              h_in,
    input  logic              n_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              h_out
);
    logic              fix_lo;
    logic              fix_hi;
    logic [DATA_W-1:0] corr;

    // Decide which nibble corrections are needed.
    always_comb begin
        fix_lo = h_in || (a[NIB_W-1:0] > 4'd9);
        fix_hi = c_in || (a > 8'h99);
        corr   = {(fix_hi ? 4'h6 : 4'h0), (fix_lo ? 4'h6 : 4'h0)};
    end

    // Apply the correction in the direction of the prior operation.
    always_comb begin
        res   = n_in ? (a - corr) : (a + corr);
        c_out = fix_hi;
        h_out = a[NIB_W] ^ res[NIB_W];
    end

endmodule

// File: rtl/alu8_core.sv
// Eight-bit ALU top. It selects the operands for the shared adder, routes
// the results of the adder, logic unit and decimal adjuster, and forms the
// flag byte. Purely combinational; assumes op values per alu8_pkg, with
// unused codes passing the inputs through.
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] acc,
    input  logic [7:0] opnd,
    input  logic [7:0] flags_in,
    input  logic [3:0] op,
    output logic [7:0] result,
    output logic [7:0] flags_out
);
    alu_op_e            op_e;
    logic [DATA_W-1:0]  as_b;
    logic               as_cin;
    logic               as_sub;
    logic [DATA_W-1:0]  as_sum;
    logic               as_half;
    logic               as_carry;
    logic               as_ovf;
    logic [1:0]         lg_sel;
    logic [DATA_W-1:0]  lg_res;
    logic [DATA_W-1:0]  da_res;
    logic               da_c;
    logic               da_h;
    logic [DATA_W-1:0]  cpl_val;

    assign op_e = alu_op_e'(op);

    // Operand, carry-in and direction selection for the shared adder.
    always_comb begin
        as_b   = ((op_e == OP_INC) || (op_e == OP_DEC)) ? 8'h01 : opnd;
        as_cin = ((op_e == OP_ADC) || (op_e == OP_SBC)) ? flags_in[FB_C] : 1'b0;
        as_sub = (op_e == OP_SUB) || (op_e == OP_SBC) ||
                 (op_e == OP_CMP) || (op_e == OP_DEC);
    end

    // Logic function selection.
    always_comb begin
        case (op_e)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a     (acc),
        .b     (as_b),
        .cin   (as_cin),
        .sub   (as_sub),
        .sum   (as_sum),
        .half  (as_half),
        .carry (as_carry),
        .ovf   (as_ovf)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a   (acc),
        .b   (opnd),
        .sel (lg_sel),
        .res (lg_res)
    );

    alu8_decadj u_decadj (
        .a     (acc),
        .c_in  (flags_in[FB_C]),
        .h_in  (flags_in[FB_H]),
        .n_in  (flags_in[FB_N]),
        .res   (da_res),
        .c_out (da_c),
        .h_out (da_h)
    );

    assign cpl_val = ~acc;

    // Result routing and flag byte formation per operation.
    always_comb begin
        result    = acc;
        flags_out = flags_in;
        case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                result    = as_sum;
                flags_out = pack_flags(as_sum[7], as_sum == '0, as_sum[5], as_half,
                                       as_sum[3], as_ovf, as_sub, as_carry);
            end
            OP_CMP: begin
                flags_out = pack_flags(as_sum[7], as_sum == '0, opnd[5], as_half,
                                       opnd[3], as_ovf, 1'b1, as_carry);
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = lg_res;
                flags_out = pack_flags(lg_res[7], lg_res == '0, lg_res[5],
                                       op_e == OP_AND, lg_res[3], even_par(lg_res),
                                       1'b0, 1'b0);
            end
            OP_INC, OP_DEC: begin
                result    = as_sum;
                flags_out = pack_flags(as_sum[7], as_sum == '0, as_sum[5], as_half,
                                       as_sum[3], as_ovf, as_sub, flags_in[FB_C]);
            end
            OP_CPL: begin
                result           = cpl_val;
                flags_out[FB_B5] = cpl_val[5];
                flags_out[FB_B3] = cpl_val[3];
                flags_out[FB_H]  = 1'b1;
                flags_out[FB_N]  = 1'b1;
            end
            OP_CCF: begin
                flags_out[FB_H]  = flags_in[FB_C];
                flags_out[FB_C]  = ~flags_in[FB_C];
                flags_out[FB_N]  = 1'b0;
                flags_out[FB_B5] = flags_in[FB_B5] | acc[5];
                flags_out[FB_B3] = flags_in[FB_B3] | acc[3];
            end
            OP_DAA: begin
                result    = da_res;
                flags_out = pack_flags(da_res[7], da_res == '0, da_res[5], da_h,
                                       da_res[3], even_par(da_res), flags_in[FB_N], da_c);
            end
            default: begin
                result    = acc;
                flags_out = flags_in;
            end
        endcase
    end

    // Operation-class invariants on the settled outputs.
    always_comb begin
        // R4
        cmp_acc_chk: assert (!(op == 4'd4) || (result == acc))
            else $error("compare altered the accumulator");
        // R6
        incdec_carry_chk: assert (!((op == 4'd8) || (op == 4'd9)) ||
                                  (flags_out[0] == flags_in[0]))
            else $error("increment/decrement changed carry");
        // R5
        logic_clear_chk: assert (!((op >= 4'd5) && (op <= 4'd7)) ||
                                 (flags_out[1:0] == 2'b00))
            else $error("logic op left carry or subtract set");
        // R3
        sub_mark_chk: assert (!((op == 4'd2) || (op == 4'd3) || (op == 4'd4) ||
                                (op == 4'd9)) || flags_out[1])
            else $error("subtracting op cleared subtract marker");
        // R8
        ccf_swap_chk: assert (!(op == 4'd11) ||
                              ((flags_out[0] != flags_in[0]) && (flags_out[4] == flags_in[0])))
            else $error("complement-carry swap wrong");
        // R10
        unused_pass_chk: assert (!(op >= 4'd13) ||
                                 ((result == acc) && (flags_out == flags_in)))
            else $error("unused code altered outputs");
    end

endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/10ps
// Self-checking bench: exhaustive operand sweep under every code against a
// bench reference model, plus directed boundary vectors.
module alu8_core_tb;

    localparam real CLK_PERIOD = 5.0;
    localparam int  WD_CYCLES  = 200000;

    logic       clk = 1'b0;
    logic [7:0] acc = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic [3:0] op = 4'd0;
    logic [7:0] result;
    logic [7:0] flags_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    alu8_core u_dut (
        .acc       (acc),
        .opnd      (opnd),
        .flags_in  (flags_in),
        .op        (op),
        .result    (result),
        .flags_out (flags_out)
    );

    function automatic logic [7:0] mkf(input logic s, z, b5, h, b3, pv, n, c);
        return {s, z, b5, h, b3, pv, n, c};
    endfunction

    function automatic int sx(input logic [7:0] v);
        return (v > 8'd127) ? int'(v) - 256 : int'(v);
    endfunction

    // Reference model: returns {result, flags}.
    function automatic logic [15:0] ref_model(input logic [3:0] o, input logic [7:0] a,
                                              input logic [7:0] b, input logic [7:0] f);
        int ci, s, ss, lo;
        logic [7:0] r, fo, corr;
        logic hi6, lo6;
        r = a; fo = f;
        ci = ((o == 4'd1) || (o == 4'd3)) ? int'(f[0]) : 0;
        case (o)
            4'd0, 4'd1: begin
                s = int'(a) + int'(b) + ci; r = s[7:0];
                lo = int'(a % 16) + int'(b % 16) + ci;
                ss = sx(a) + sx(b) + ci;
                fo = mkf(r[7], r == 0, r[5], lo > 15, r[3], (ss > 127) || (ss < -128), 1'b0, s > 255);
            end
            4'd2, 4'd3, 4'd4: begin
                s = int'(a) - int'(b) - ci; r = s[7:0];
                lo = int'(a % 16) - int'(b % 16) - ci;
                ss = sx(a) - sx(b) - ci;
                if (o == 4'd4)
                    fo = mkf(r[7], r == 0, b[5], lo < 0, b[3], (ss > 127) || (ss < -128), 1'b1, s < 0);
                else
                    fo = mkf(r[7], r == 0, r[5], lo < 0, r[3], (ss > 127) || (ss < -128), 1'b1, s < 0);
                if (o == 4'd4) r = a;
            end
            4'd5, 4'd6, 4'd7: begin
                r = (o == 4'd5) ? (a & b) : (o == 4'd6) ? (a | b) : (a ^ b);
                fo = mkf(r[7], r == 0, r[5], o == 4'd5, r[3], ($countones(r) % 2) == 0, 1'b0, 1'b0);
            end
            4'd8: begin
                r = a + 8'd1;
                fo = mkf(r[7], r == 0, r[5], (a % 16) == 15, r[3], a == 8'h7F, 1'b0, f[0]);
            end
            4'd9: begin
                r = a - 8'd1;
                fo = mkf(r[7], r == 0, r[5], (a % 16) == 0, r[3], a == 8'h80, 1'b1, f[0]);
            end
            4'd10: begin
                r = ~a; fo[5] = r[5]; fo[3] = r[3]; fo[4] = 1'b1; fo[1] = 1'b1;
            end
            4'd11: begin
                fo[4] = f[0]; fo[0] = ~f[0]; fo[1] = 1'b0;
                fo[5] = f[5] | a[5]; fo[3] = f[3] | a[3];
            end
            4'd12: begin
                hi6 = f[0] || (a > 8'h99);
                lo6 = f[4] || ((a % 16) > 9);
                corr = (lo6 ? 8'h06 : 8'h00) + (hi6 ? 8'h60 : 8'h00);
                r = f[1] ? (a - corr) : (a + corr);
                fo = mkf(r[7], r == 0, r[5], a[4] ^ r[4], r[3], ($countones(r) % 2) == 0, f[1], hi6);
            end
            default: begin r = a; fo = f; end
        endcase
        return {r, fo};
    endfunction

    function automatic string req_of(input int o);
        case (o)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4:       return "R4";
            5, 6, 7: return "R5";
            8, 9:    return "R6";
            10:      return "R7";
            11:      return "R8";
            12:      return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] er, input logic [7:0] ef);
        checks++;
        if ((result !== er) || (flags_out !== ef)) begin
            errors++;
            $display("FAIL %s op=%0d acc=%h opnd=%h fin=%h actual r=%h f=%h expected r=%h f=%h",
                     tag, op, acc, opnd, flags_in, result, flags_out, er, ef);
        end
    endtask

    task automatic vec(input string tag, input logic [3:0] o, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f,
                       input logic [7:0] er, input logic [7:0] ef);
        op = o; acc = a; opnd = b; flags_in = f;
        #1;
        check(tag, er, ef);
        #1;
    endtask

    initial begin
        logic [15:0] exp;
        logic [7:0]  fin;
        void'($urandom(32'd20240611));
        #1;
        // R1 R2: idle inputs (add 0+0) give zero result with only zero flag
        check("R1 R2 idle", 8'h00, 8'h40);
        #1;
        vec("R2 add overflow", 4'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94);
        vec("R2 adc wrap", 4'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h51);
        vec("R3 sub overflow", 4'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h3E);
        vec("R4 compare", 4'd4, 8'h10, 8'h28, 8'h00, 8'h10, 8'hBB);
        vec("R5 and zero", 4'd5, 8'hF0, 8'h0F, 8'hFF, 8'h00, 8'h54);
        vec("R6 inc keeps carry", 4'd8, 8'hFF, 8'h33, 8'h01, 8'h00, 8'h51);
        vec("R6 dec overflow", 4'd9, 8'h80, 8'hFF, 8'h00, 8'h7F, 8'h3E);
        vec("R7 complement", 4'd10, 8'h5A, 8'h00, 8'h00, 8'hA5, 8'h32);
        vec("R8 complement carry", 4'd11, 8'h28, 8'h00, 8'h01, 8'h28, 8'h38);
        vec("R9 adjust add", 4'd12, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h55);
        vec("R9 adjust sub", 4'd12, 8'h0F, 8'h00, 8'h02, 8'h09, 8'h0E);
        vec("R10 unused code", 4'd14, 8'h12, 8'h34, 8'hA5, 8'h12, 8'hA5);
        // Exhaustive sweep: every code, acc/opnd pair and carry value
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        fin = 8'($urandom);
                        fin[0] = c[0];
                        fin[1] = a[0] ^ b[0];
                        fin[4] = b[1];
                        op = 4'(o); acc = 8'(a); opnd = 8'(b); flags_in = fin;
                        #0.05;
                        exp = ref_model(op, acc, opnd, flags_in);
                        check({req_of(o), " R1 sweep"}, exp[15:8], exp[7:0]);
                        #0.05;
                    end
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        if (!done) begin
            errors++;
            $display("FAIL all requirements: watchdog expired, actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule